// File: doc/BRIEF.md
# Serial DAC Input Register Front End

This block is the device-side digital logic of a single-channel 16-bit voltage DAC that is programmed over a three-wire serial port. A frame-select line (`sync_n`, active low) marks a write sequence. One data bit is taken from `din` on every falling edge of `sclk`, most significant bit first. A complete frame has 24 bits. The first six bits are padding. The next two bits select the operating mode. The last sixteen bits are the DAC code. On the 24th falling edge the code and the mode are committed together, and a one-period update strobe is raised.

The serial input behaves as a stream with no back-pressure. `sync_n` low acts as the valid qualifier for each falling edge of `sclk`, and the block always accepts the bit, so there is no ready signal. A frame that is cut short by `sync_n` rising before its 24th bit is discarded without any side effect. Bits clocked in after the 24th while `sync_n` stays low are ignored. The next frame can only start after `sync_n` has gone high and then low again.

The power-on value of the DAC code is chosen when the block is built: zero-scale or mid-scale. The code register is kept unchanged while the output is in any power-down mode. The mode drives a one-hot output-load select for the analog switches, which lie outside this block.

Top module: `sdac_frontend`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dac_code` is 0x0000 when `MIDSCALE_POR`=0 and 0x8000 when `MIDSCALE_POR`=1. At the same time `pd_mode` is 00, `load_sel` is 4'b0001 and `dac_update` is 0.
- R2: While `sync_n` is low, `din` is sampled on each falling edge of `sclk`, most significant bit first. The values of the first six bits of a frame have no effect on any output.
- R3: On the 24th falling edge of a frame, `dac_code` takes bits 15:0 of the frame (the last 16 bits sent) and `pd_mode` takes bits 17:16 (the 7th and 8th bits sent).
- R4: If `sync_n` rises before the 24th falling edge, the partial frame is discarded. `dac_code`, `pd_mode` and `dac_update` do not change, and the next frame is assembled from its own first bit.
- R5: Falling edges after the 24th while `sync_n` stays low cause no further update and no strobe.
- R6: A new frame starts only after `sync_n` has been high for at least one falling edge and then goes low again.
- R7: `load_sel` is one-hot and decoded from `pd_mode`: bit0 for mode 00 (normal, amplifier drives), bit1 for 01 (1 kΩ to ground), bit2 for 10 (100 kΩ to ground), bit3 for 11 (open).
- R8: The code carried by a frame is loaded whatever its mode field. While the block stays in a power-down mode, `dac_code` holds that value.
- R9: `dac_update` is high from the falling edge that commits a frame until the next falling edge of `sclk`, and it is high at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sclk | input | 1 | Serial clock; data taken on falling edges |
| sync_n | input | 1 | Frame select, active low; a rise aborts an unfinished frame |
| din | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Committed DAC code |
| pd_mode | output | 2 | Committed operating mode (00 normal, others power-down) |
| load_sel | output | 4 | One-hot output-load select |
| dac_update | output | 1 | Strobe, high for one `sclk` period after a commit |

## Verification
The two functions that can meet in one `sclk` period are the frame commit on the 24th falling edge and the frame abort caused by `sync_n` rising. The bench raises `sync_n` in the half-period right after the 24th falling edge, where the commit must stand. It also raises `sync_n` after only 20 edges, where nothing may change. It then holds `sync_n` low for 24 extra edges, which carry a different word that must not be committed. A behavioural model built on a bit queue follows every falling edge, and on each rising edge the bench compares all four outputs against it, alongside directed checks of the expected register values.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int MODE_W = 2;
  localparam int LOAD_W = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    PD_NONE = 2'b00,
    PD_1K   = 2'b01,
    PD_100K = 2'b10,
    PD_OPEN = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int PAD_W  = 6,
  parameter int CODE_W = 16
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                sync_n,
  input  logic                din,
  output logic                commit,
  output logic [CODE_W+1:0]   payload
);
  import sdac_pkg::*;

  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [CODE_W:0]  sr;   // only the payload bits are kept; padding falls off

  always_ff @(negedge sclk or negedge rst_n or posedge sync_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (sync_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (cnt != CNT_FULL) begin
      cnt <= cnt + 1'b1;
      sr  <= {sr[CODE_W-1:0], din};
    end
  end

  assign commit  = !sync_n && (cnt == CNT_LAST);
  assign payload = {sr, din};

  // R4
  idle_clear_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    sync_n |-> (cnt == '0));

  // R5
  cnt_cap_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    (cnt == CNT_FULL && !sync_n) |=> (cnt == CNT_FULL || cnt == '0));
endmodule

// File: rtl/sdac_commit.sv
module sdac_commit #(
  parameter int CODE_W        = 16,
  parameter bit MIDSCALE_POR  = 1'b0
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [CODE_W+1:0]  payload,
  output logic [CODE_W-1:0]  code,
  output sdac_pkg::pd_mode_e mode,
  output logic               upd
);
  import sdac_pkg::*;

  localparam logic [CODE_W-1:0] POR_CODE =
    MIDSCALE_POR ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      code <= POR_CODE;
      mode <= PD_NONE;
      upd  <= 1'b0;
    end else begin
      upd <= commit;
      if (commit) begin
        code <= payload[CODE_W-1:0];
        mode <= pd_mode_e'(payload[CODE_W+MODE_W-1:CODE_W]);
      end
    end
  end

  // R9
  write_strobe_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    (code != $past(code) || mode != $past(mode)) |-> upd);

  // R8
  pd_hold_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    (mode != PD_NONE && !upd) |-> $stable(code));
endmodule

// File: rtl/sdac_load_decode.sv
module sdac_load_decode (
  input  sdac_pkg::pd_mode_e              mode,
  output logic [sdac_pkg::LOAD_W-1:0]     load_sel
);
  import sdac_pkg::*;

  for (genvar g = 0; g < LOAD_W; g++) begin : g_sel
    assign load_sel[g] = (mode == pd_mode_e'(g));
  end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
  parameter int PAD_W        = 6,
  parameter int CODE_W       = 16,
  parameter bit MIDSCALE_POR = 1'b0
) (
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              din,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pd_mode,
  output logic [3:0]        load_sel,
  output logic              dac_update
);
  import sdac_pkg::*;

  logic              commit;
  logic [CODE_W+1:0] payload;
  pd_mode_e          mode_q;

  sdac_shifter #(.PAD_W(PAD_W), .CODE_W(CODE_W)) u_shift (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .sync_n  (sync_n),
    .din     (din),
    .commit  (commit),
    .payload (payload)
  );

  sdac_commit #(.CODE_W(CODE_W), .MIDSCALE_POR(MIDSCALE_POR)) u_commit (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .commit  (commit),
    .payload (payload),
    .code    (dac_code),
    .mode    (mode_q),
    .upd     (dac_update)
  );

  sdac_load_decode u_dec (
    .mode     (mode_q),
    .load_sel (load_sel)
  );

  assign pd_mode = mode_q;

  // R7
  load_onehot_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    $countones(load_sel) == 1);

  // R3
  strobe_from_frame_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    commit |=> dac_update);
endmodule

// File: tb/sdac_frontend_test.sv
`timescale 1ns/1ps
module sdac_frontend_test;
  localparam bit MID = 1'b1;

  logic        rst_n = 1'b0;
  logic        sclk  = 1'b0;
  logic        sync_n = 1'b1;
  logic        din   = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic [3:0]  load_sel;
  logic        dac_update;

  int  total = 0;
  int  fails = 0;
  bit  running = 0;
  bit  finished = 0;

  always #10 sclk = ~sclk;

  sdac_frontend #(.MIDSCALE_POR(MID)) uut (
    .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
    .dac_code(dac_code), .pd_mode(pd_mode), .load_sel(load_sel),
    .dac_update(dac_update)
  );

  // behavioural reference model
  bit          q[$];
  bit          m_done;
  logic [15:0] m_code;
  logic [1:0]  m_mode;
  logic        m_upd;

  always @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_done = 0; m_upd = 0;
      m_code = MID ? 16'h8000 : 16'h0000; m_mode = 2'b00;
    end else if (sync_n) begin
      q.delete(); m_done = 0; m_upd = 0;
    end else if (m_done) begin
      m_upd = 0;
    end else begin
      logic [23:0] w;
      q.push_back(din);
      m_upd = 0;
      if (q.size() == 24) begin
        w = '0;
        foreach (q[i]) w = {w[22:0], q[i]};
        m_code = w[15:0];
        m_mode = w[17:16];
        m_upd  = 1;
        m_done = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge sclk) begin
    if (running && rst_n) begin
      chk("R3 code vs model", dac_code, m_code);
      chk("R3 mode vs model", pd_mode, m_mode);
      chk("R7 load_sel vs model", load_sel, 4'b0001 << m_mode);
      chk("R9 strobe vs model", dac_update, m_upd);
    end
  end

  task automatic send(input logic [23:0] w, input int nbits,
                      input logic [23:0] xw, input int nx, input bit raise);
    @(posedge sclk); sync_n = 1'b0; din = w[23];
    for (int i = 1; i < nbits; i++) begin
      @(posedge sclk); din = w[23-i];
    end
    for (int i = 0; i < nx; i++) begin
      @(posedge sclk); din = xw[23-i];
    end
    @(posedge sclk); if (raise) sync_n = 1'b1;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      running  = 0;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge sclk);
    #1;
    chk("R1 reset code", dac_code, 16'h8000);
    chk("R1 reset mode", pd_mode, 0);
    chk("R1 reset load_sel", load_sel, 4'b0001);
    chk("R1 reset strobe", dac_update, 0);
    @(posedge sclk); rst_n = 1'b1; running = 1;
    repeat (2) @(posedge sclk);
    #1;
    chk("R1 code after release", dac_code, 16'h8000);

    // R2: padding all ones, normal mode
    send({6'h3F, 2'b00, 16'h1234}, 24, '0, 0, 1);
    chk("R3 strobe after commit", dac_update, 1);
    chk("R2 code with padding ignored", dac_code, 16'h1234);
    chk("R2 mode with padding ignored", pd_mode, 0);

    // R8: power-down frame still loads its code
    send({6'h00, 2'b01, 16'hABCD}, 24, '0, 0, 1);
    chk("R8 code loaded in power-down", dac_code, 16'hABCD);
    chk("R7 1k select", load_sel, 4'b0010);

    // R4: abort after 20 edges
    send({6'h00, 2'b10, 16'h5555}, 20, '0, 0, 1);
    repeat (2) @(posedge sclk); #1;
    chk("R4 code after abort", dac_code, 16'hABCD);
    chk("R4 mode after abort", pd_mode, 1);
    chk("R4 no strobe after abort", dac_update, 0);

    // R4: next frame assembled fresh
    send({6'h2A, 2'b10, 16'h0F0F}, 24, '0, 0, 1);
    chk("R4 fresh frame code", dac_code, 16'h0F0F);
    chk("R7 100k select", load_sel, 4'b0100);

    // R5: extra edges while sync_n stays low
    send({6'h00, 2'b11, 16'hFFFF}, 24, {6'h00, 2'b00, 16'h0001}, 24, 0);
    chk("R5 code kept after extra edges", dac_code, 16'hFFFF);
    chk("R5 mode kept after extra edges", pd_mode, 3);
    chk("R5 no second strobe", dac_update, 0);
    chk("R7 open select", load_sel, 4'b1000);
    @(posedge sclk); sync_n = 1'b1;

    // R6: new frame after sync_n high then low
    send({6'h00, 2'b00, 16'h0000}, 24, '0, 0, 1);
    chk("R6 new frame code", dac_code, 16'h0000);
    chk("R6 new frame mode", pd_mode, 0);

    // R8: code held through power-down idle
    send({6'h00, 2'b10, 16'h7777}, 24, '0, 0, 1);
    repeat (10) @(posedge sclk); #1;
    chk("R8 code held in power-down", dac_code, 16'h7777);
    chk("R9 strobe low when idle", dac_update, 0);

    repeat (3) @(posedge sclk);
    finish_run();
  end
endmodule